// File: doc/BRIEF.md
# Polled Byte-Transfer Controller

This block sits on the device side of a simple processor bus and moves one byte at a time to an attached peripheral. Software drives it purely by polling three word-addressed registers: a command register, a read-only status register, and a data register. Software first reads status until the busy bit is clear. It then writes the direction bit, loads the data byte, and finally writes the command register with the ready bit set.

The controller sees the ready bit and raises busy. It then samples the direction bit and the data byte and hands them to the peripheral over a request/done handshake. When the peripheral finishes, the controller steps down in a fixed order: first it drops ready, on the next edge it clears error, and on the edge after that it clears busy. A peripheral failure ends the transfer at once, with error raised and busy dropped together. Bus writes that arrive while busy is set are discarded and leave behind a sticky overrun mark.

Top module: `pollctl_top`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 0 and dev_req is 0.
- R2: Reads are combinational from registers. Offset 0 gives bit 0 = write direction and bit 1 = command ready. Offset 1 gives bit 0 = busy, bit 1 = error and bit 2 = overrun. Offset 2 gives the data byte. Offset 3 and all unused bits read 0.
- R3: A command write that sets ready while busy is 0 lands on one clock edge. Busy reads 1 after the next edge.
- R4: dev_req rises one edge after busy does and is only high while busy is 1. For as long as it stays high, dev_write carries the sampled direction bit and dev_data carries the sampled data byte, and both hold steady.
- R5: The edge that samples dev_done drops dev_req and clears ready. The next edge clears error. The edge after that clears busy. The direction bit is kept.
- R6: The edge that samples dev_fail during a transfer sets error and clears busy, ready and dev_req together. Error stays set until the clearing step of a later successful transfer.
- R7: A write to offset 0 or offset 2 while busy is 1 leaves those registers unchanged. It also sets overrun, which stays set until reset.
- R8: Writes to offset 1 or offset 3 change no register.
- R9: dev_done or dev_fail asserted while dev_req is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | AW | Word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr |
| dev_req | output | 1 | Transfer request to the peripheral |
| dev_write | output | 1 | Direction of the current transfer |
| dev_data | output | DW | Byte handed to the peripheral |
| dev_done | input | 1 | Peripheral finished successfully |
| dev_fail | input | 1 | Peripheral reports failure |

## Verification
The hardest state to reach is a bus write that arrives during the short window while a transfer is in flight. The stimulus reaches it by giving the peripheral stand-in a long delay, so that both data and command writes land while busy is set. The exact three-edge step-down is checked by counting falling edges from the drop of dev_req to the first status read with busy clear. Failure, zero-delay completion and a spurious done with no request open are all driven from the peripheral stand-in. A behavioural model is compared against every read and every handshake output on every cycle.

// File: rtl/pollctl_pkg.sv
package pollctl_pkg;
  localparam int unsigned OFS_CMD  = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_DATA = 2;

  localparam int CMD_WR_BIT  = 0;
  localparam int CMD_RDY_BIT = 1;
  localparam int ST_BUSY_BIT = 0;
  localparam int ST_ERR_BIT  = 1;
  localparam int ST_OVR_BIT  = 2;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_LAUNCH,
    SEQ_XFER,
    SEQ_CLR_ERR,
    SEQ_CLR_BUSY
  } seq_state_e;
endpackage

// File: rtl/pollctl_regs.sv
module pollctl_regs
  import pollctl_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          busy,
  input  logic          error,
  input  logic          clr_rdy,
  output logic          cmd_wr,
  output logic          cmd_rdy,
  output logic [DW-1:0] data_out
);
  localparam logic [AW-1:0] A_CMD  = AW'(OFS_CMD);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);

  logic          hit_cmd, hit_dat, blocked;
  logic          cmd_en, data_en, ovr_en;
  logic          cmd_wr_q, cmd_wr_d, cmd_rdy_q, cmd_rdy_d;
  logic [DW-1:0] data_q;
  logic          ovr_q;

  always_comb begin
    hit_cmd   = bus_sel & bus_we & (bus_addr == A_CMD);
    hit_dat   = bus_sel & bus_we & (bus_addr == A_DATA);
    blocked   = busy & (hit_cmd | hit_dat);
    cmd_en    = (hit_cmd & ~busy) | clr_rdy;
    data_en   = hit_dat & ~busy;
    ovr_en    = blocked;
    cmd_wr_d  = cmd_wr_q;
    cmd_rdy_d = cmd_rdy_q;
    if (clr_rdy) begin
      cmd_rdy_d = 1'b0;
    end else if (hit_cmd) begin
      cmd_wr_d  = bus_wdata[CMD_WR_BIT];
      cmd_rdy_d = bus_wdata[CMD_RDY_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wr_q  <= 1'b0;
      cmd_rdy_q <= 1'b0;
      data_q    <= '0;
      ovr_q     <= 1'b0;
    end else begin
      if (cmd_en) begin
        cmd_wr_q  <= cmd_wr_d;
        cmd_rdy_q <= cmd_rdy_d;
      end
      if (data_en) data_q <= bus_wdata;
      if (ovr_en)  ovr_q  <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CMD: begin
        bus_rdata[CMD_WR_BIT]  = cmd_wr_q;
        bus_rdata[CMD_RDY_BIT] = cmd_rdy_q;
      end
      A_STAT: begin
        bus_rdata[ST_BUSY_BIT] = busy;
        bus_rdata[ST_ERR_BIT]  = error;
        bus_rdata[ST_OVR_BIT]  = ovr_q;
      end
      A_DATA:  bus_rdata = data_q;
      default: bus_rdata = '0;
    endcase
  end

  assign cmd_wr   = cmd_wr_q;
  assign cmd_rdy  = cmd_rdy_q;
  assign data_out = data_q;

  // R7: data write while busy is dropped and marks overrun
  a_r7_data_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == A_DATA && busy) |=> ($stable(data_q) && ovr_q));
  // R7: command write while busy leaves command bits alone
  a_r7_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == A_CMD && busy && !clr_rdy) |=> $stable({cmd_wr_q, cmd_rdy_q}));
  // R7: overrun is sticky
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/pollctl_seq.sv
module pollctl_seq
  import pollctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_rdy,
  input  logic [DW-1:0] data_out,
  input  logic          dev_done,
  input  logic          dev_fail,
  output logic          busy,
  output logic          error,
  output logic          clr_rdy,
  output logic          dev_req,
  output logic          dev_write,
  output logic [DW-1:0] dev_data
);
  seq_state_e    st_q, st_d;
  logic          busy_q, busy_d, err_q, err_d, req_q, req_d;
  logic          dwr_q;
  logic [DW-1:0] dd_q;
  logic          load;

  always_comb begin
    st_d    = st_q;
    busy_d  = busy_q;
    err_d   = err_q;
    req_d   = req_q;
    clr_rdy = 1'b0;
    load    = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (cmd_rdy) begin
          busy_d = 1'b1;
          st_d   = SEQ_LAUNCH;
        end
      end
      SEQ_LAUNCH: begin
        load  = 1'b1;
        req_d = 1'b1;
        st_d  = SEQ_XFER;
      end
      SEQ_XFER: begin
        if (dev_fail) begin
          req_d   = 1'b0;
          clr_rdy = 1'b1;
          err_d   = 1'b1;
          busy_d  = 1'b0;
          st_d    = SEQ_IDLE;
        end else if (dev_done) begin
          req_d   = 1'b0;
          clr_rdy = 1'b1;
          st_d    = SEQ_CLR_ERR;
        end
      end
      SEQ_CLR_ERR: begin
        err_d = 1'b0;
        st_d  = SEQ_CLR_BUSY;
      end
      SEQ_CLR_BUSY: begin
        busy_d = 1'b0;
        st_d   = SEQ_IDLE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      req_q  <= 1'b0;
      dwr_q  <= 1'b0;
      dd_q   <= '0;
    end else begin
      st_q   <= st_d;
      busy_q <= busy_d;
      err_q  <= err_d;
      req_q  <= req_d;
      if (load) begin
        dwr_q <= cmd_wr;
        dd_q  <= data_out;
      end
    end
  end

  assign busy      = busy_q;
  assign error     = err_q;
  assign dev_req   = req_q;
  assign dev_write = dwr_q;
  assign dev_data  = dd_q;

  // R3: busy only rises after ready was seen
  a_r3_busy_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_rdy));
  // R4: request only while busy
  a_r4_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> busy);
  // R4: payload steady during request
  a_r4_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && $past(dev_req)) |-> ($stable(dev_data) && $stable(dev_write)));
  // R5: busy drops last, after ready and error are already clear
  a_r5_busy_last: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !error) |-> ($past(!cmd_rdy) && $past(!error)));
  // R6: failure raises error with busy, ready and request already down
  a_r6_fail_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (!busy && !dev_req));
endmodule

// File: rtl/pollctl_top.sv
module pollctl_top #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          dev_req,
  output logic          dev_write,
  output logic [DW-1:0] dev_data,
  input  logic          dev_done,
  input  logic          dev_fail
);
  logic          busy, error, clr_rdy, cmd_wr, cmd_rdy;
  logic [DW-1:0] data_out;

  pollctl_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .error(error), .clr_rdy(clr_rdy),
    .cmd_wr(cmd_wr), .cmd_rdy(cmd_rdy), .data_out(data_out)
  );

  pollctl_seq #(.DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_rdy(cmd_rdy), .data_out(data_out),
    .dev_done(dev_done), .dev_fail(dev_fail),
    .busy(busy), .error(error), .clr_rdy(clr_rdy),
    .dev_req(dev_req), .dev_write(dev_write), .dev_data(dev_data)
  );

  // R9: completion strobes without an open request start nothing
  a_r9_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_req && !busy && !cmd_rdy) |=> !dev_req);
endmodule

// File: tb/pollctl_top_tb_top.sv
module pollctl_top_tb_top;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          dev_req, dev_write;
  logic [DW-1:0] dev_data;
  logic          dev_done = 1'b0, dev_fail = 1'b0;

  pollctl_top #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_req(dev_req), .dev_write(dev_write), .dev_data(dev_data),
    .dev_done(dev_done), .dev_fail(dev_fail)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_wr = 0, m_rdy = 0, m_data = 0, m_busy = 0, m_err = 0, m_ovr = 0;
  int m_req = 0, m_dw = 0, m_dd = 0, m_ph = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wr = 0; m_rdy = 0; m_data = 0; m_busy = 0; m_err = 0; m_ovr = 0;
      m_req = 0; m_dw = 0; m_dd = 0; m_ph = 0;
    end else begin
      int o_wr, o_rdy, o_data, o_busy;
      o_wr = m_wr; o_rdy = m_rdy; o_data = m_data; o_busy = m_busy;
      if (bus_sel && bus_we && (bus_addr == 0 || bus_addr == 2)) begin
        if (o_busy != 0) m_ovr = 1;
        else if (bus_addr == 0) begin m_wr = bus_wdata[0]; m_rdy = bus_wdata[1]; end
        else m_data = bus_wdata;
      end
      case (m_ph)
        0: if (o_rdy != 0) begin m_busy = 1; m_ph = 1; end
        1: begin m_req = 1; m_dw = o_wr; m_dd = o_data; m_ph = 2; end
        2: if (dev_fail) begin m_req = 0; m_rdy = 0; m_err = 1; m_busy = 0; m_ph = 0; end
           else if (dev_done) begin m_req = 0; m_rdy = 0; m_ph = 3; end
        3: begin m_err = 0; m_ph = 4; end
        default: begin m_busy = 0; m_ph = 0; end
      endcase
    end
  end

  // per-cycle comparison and watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int exp_rd;
      case (bus_addr)
        2'd0: exp_rd = m_rdy * 2 + m_wr;
        2'd1: exp_rd = m_ovr * 4 + m_err * 2 + m_busy;
        2'd2: exp_rd = m_data;
        default: exp_rd = 0;
      endcase
      check(int'(bus_rdata) == exp_rd, "R2 model readback", int'(bus_rdata), exp_rd);
      check(int'(dev_req) == m_req, "R4 model request", int'(dev_req), m_req);
      if (m_req != 0) begin
        check(int'(dev_write) == m_dw, "R4 model direction", int'(dev_write), m_dw);
        check(int'(dev_data) == m_dd, "R4 model payload", int'(dev_data), m_dd);
      end
    end
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // peripheral stand-in
  int dev_delay = 2, dcnt = 0;
  bit fail_next = 0, stray = 0;
  always @(posedge clk) begin
    #1;
    if (dev_done || dev_fail) begin
      dev_done = 1'b0; dev_fail = 1'b0;
    end else if (dev_req) begin
      if (dcnt >= dev_delay) begin
        if (fail_next) dev_fail = 1'b1; else dev_done = 1'b1;
        dcnt = 0;
      end else dcnt++;
    end else if (stray) begin
      dev_done = 1'b1;
      stray = 0;
    end
  end

  task automatic bus_wr(input int a, input int d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(posedge clk); #1;
    bus_addr = AW'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic wait_idle();
    int v;
    do rd(1, v); while (v[0]);
  endtask

  initial begin
    int v, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(0, v); check(v == 0, "R1 command after reset", v, 0);
    rd(1, v); check(v == 0, "R1 status after reset", v, 0);
    rd(2, v); check(v == 0, "R1 data after reset", v, 0);
    check(dev_req == 1'b0, "R1 request after reset", int'(dev_req), 0);

    bus_wr(2, 8'hA5);
    rd(2, v); check(v == 8'hA5, "R2 data readback", v, 8'hA5);
    rd(3, v); check(v == 0, "R2 offset 3 reads zero", v, 0);

    // transfer 1: write direction, long device delay
    dev_delay = 10;
    bus_wr(0, 3);
    bus_addr = 2'd1;
    @(negedge clk); check(bus_rdata[0] == 1'b0, "R3 busy not yet set", int'(bus_rdata[0]), 0);
    @(negedge clk); check(bus_rdata[0] == 1'b1, "R3 busy set", int'(bus_rdata[0]), 1);
    check(dev_req == 1'b0, "R4 request follows busy", int'(dev_req), 0);
    @(negedge clk); check(dev_req == 1'b1, "R4 request raised", int'(dev_req), 1);
    check(dev_write == 1'b1, "R4 direction", int'(dev_write), 1);
    check(dev_data == 8'hA5, "R4 payload", int'(dev_data), 8'hA5);
    bus_wr(2, 8'h11);
    bus_wr(0, 0);
    rd(2, v); check(v == 8'hA5, "R7 data held while busy", v, 8'hA5);
    rd(0, v); check(v == 3, "R7 command held while busy", v, 3);
    rd(1, v); check(v[2] == 1'b1, "R7 overrun set", v[2], 1);
    @(posedge clk); #1 bus_addr = 2'd1;
    do @(negedge clk); while (dev_req);
    n = 1;
    while (bus_rdata[0]) begin @(negedge clk); n++; end
    check(n == 3, "R5 busy clears third edge after done", n, 3);
    rd(0, v); check(v == 1, "R5 ready cleared, direction kept", v, 1);

    // transfer 2: read direction, zero delay
    dev_delay = 0;
    bus_wr(2, 8'h3C);
    bus_wr(0, 2);
    do @(negedge clk); while (!dev_req);
    check(dev_write == 1'b0, "R4 read direction", int'(dev_write), 0);
    check(dev_data == 8'h3C, "R4 second payload", int'(dev_data), 8'h3C);
    wait_idle();
    rd(0, v); check(v == 0, "R5 ready cleared after read", v, 0);

    // transfer 3: failure
    dev_delay = 2; fail_next = 1;
    bus_wr(0, 3);
    do @(negedge clk); while (!dev_req);
    @(posedge clk); #1 bus_addr = 2'd1;
    do @(negedge clk); while (dev_req);
    check(bus_rdata[1:0] == 2'b10, "R6 error set with busy clear", int'(bus_rdata[1:0]), 2);
    rd(0, v); check(v == 1, "R6 ready cleared on failure", v, 1);
    fail_next = 0;
    rd(1, v); check(v == 6, "R6 error held, R7 overrun sticky", v, 6);

    // transfer 4: success clears error
    dev_delay = 1;
    bus_wr(0, 3);
    @(negedge clk);
    wait_idle();
    rd(1, v); check(v == 4, "R6 error cleared by good transfer", v, 4);

    // R8: status and offset 3 writes
    bus_wr(1, 8'hFF);
    rd(1, v); check(v == 4, "R8 status write ignored", v, 4);
    bus_wr(3, 8'hFF);
    rd(0, v); check(v == 1, "R8 command untouched", v, 1);
    rd(2, v); check(v == 8'h3C, "R8 data untouched", v, 8'h3C);

    // R9: stray completion strobe
    stray = 1;
    repeat (4) @(negedge clk);
    check(dev_req == 1'b0, "R9 no request from stray done", int'(dev_req), 0);
    rd(1, v); check(v == 4, "R9 status unchanged", v, 4);
    rd(0, v); check(v == 1, "R9 command unchanged", v, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule